// File: doc/BRIEF.md
# Block Lock Write Protection Unit

This unit sits beside the command engine of a serial nonvolatile memory and keeps the protection part of its status register: a sticky protect-enable bit and a three-bit lock code. It builds the 8-bit status byte from those bits and from the write-enable latch and busy flag that the command engine supplies. It also answers two questions every cycle: may a status-register write commit now, and may a byte at the presented array address be programmed now.

The lock code selects one of eight protected regions. Four of them are counted from the top of the array (none, upper quarter, upper half, all). The other four are counted from address zero (the first 1, 2, 4 or 8 pages). When the write-protect pin is low and the protect-enable bit is set, all status writes are refused. In this state the lock code and the enable bit cannot be changed, so the locked region acts as a ROM while the pin is held low. Page writes ask for a permit byte by byte, so a page that straddles the lock boundary keeps its locked bytes unchanged.

Top module: `wlock_unit`

## Requirements
- R1: After reset the status byte is 8'h00 when `wel` and `busy` are low (protect-enable and lock code start at the parameter values, zero by default). Bit 7 is protect-enable, bits 6:5 always read 0, bits 4:2 are the lock code, bit 1 mirrors `wel` and bit 0 mirrors `busy`.
- R2: A committed status write copies `sw_data[7]` into protect-enable and `sw_data[4:2]` into the lock code. `sw_data` bits 6, 5, 1 and 0 have no effect, and the change is visible on `status` the cycle after the commit.
- R3: A status write is refused, and the status byte is left unchanged, when `wel` is 0 or `busy` is 1.
- R4: While `wp_pin` is 0 and protect-enable is 1, `stat_permit` is 0 and every status write is refused, including writes to the lock code and to protect-enable.
- R5: When `wp_pin` is 1, or when protect-enable is 0, the pin does not block status writes.
- R6: Lock codes 3'b000, 3'b001, 3'b010 and 3'b011 protect no address, 15'h6000–15'h7FFF, 15'h4000–15'h7FFF and the whole array, in that order.
- R7: Lock codes 3'b100, 3'b101, 3'b110 and 3'b111 protect 15'h000–15'h03F, 15'h000–15'h07F, 15'h000–15'h0FF and 15'h000–15'h1FF, in that order.
- R8: `arr_permit` is 0 for a locked address whatever the state of the pin and protect-enable. Under hardware protection, an unlocked address is still permitted.
- R9: If `wp_pin` falls while `sw_active` is 1 and protect-enable is 1, the commit of that transfer is refused even if the pin has gone high again. A fall while protect-enable is 0 has no effect.
- R10: `arr_permit` is 0 whenever `wel` is 0 or `busy` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wp_pin | input | 1 | Write-protect pin, low = protect request |
| sw_active | input | 1 | A status-write transfer is being shifted in |
| sw_commit | input | 1 | One-cycle request to commit the status write |
| sw_data | input | 8 | Status byte carried by the write |
| wel | input | 1 | Write-enable latch state |
| busy | input | 1 | Internal write cycle in progress |
| arr_addr | input | 15 | Array byte address to be judged |
| status | output | 8 | Assembled status byte |
| arr_permit | output | 1 | Byte at `arr_addr` may be programmed |
| stat_permit | output | 1 | A status-write commit would be accepted |

## Verification
The assertions assume that `sw_commit` is only pulsed while `sw_active` is high, and that `wp_pin` changes at least one cycle before a commit rather than in the same cycle. The bench drives every input on the falling clock edge. It raises the transfer flag before each commit and moves the pin only in cycles that are separate from the commit. The properties therefore see the protection state settled before each decision.

// File: rtl/wlock_pkg.sv
package wlock_pkg;

    localparam int STAT_W = 8;

    // Lock code meanings; the encoding is fixed by behaviour.
    typedef enum logic [2:0] {
        LK_NONE  = 3'b000,
        LK_TOP_Q = 3'b001,
        LK_TOP_H = 3'b010,
        LK_ALL   = 3'b011,
        LK_PG1   = 3'b100,
        LK_PG2   = 3'b101,
        LK_PG4   = 3'b110,
        LK_PG8   = 3'b111
    } lock_code_t;

    typedef struct packed {
        logic       pen;   // sticky protect-enable
        lock_code_t code;  // lock region selector
    } prot_cfg_t;

    // Status byte field positions.
    localparam int POS_PEN  = 7;
    localparam int POS_CODE = 2;
    localparam int POS_WEL  = 1;
    localparam int POS_BUSY = 0;

    function automatic logic [STAT_W-1:0] pack_status(input prot_cfg_t c,
                                                      input logic wel,
                                                      input logic busy);
        logic [STAT_W-1:0] s;
        s = '0;
        s[POS_PEN]               = c.pen;
        s[POS_CODE+2:POS_CODE]   = c.code;
        s[POS_WEL]               = wel;
        s[POS_BUSY]              = busy;
        return s;
    endfunction

    function automatic prot_cfg_t unpack_cfg(input logic [STAT_W-1:0] d);
        prot_cfg_t c;
        c.pen  = d[POS_PEN];
        c.code = lock_code_t'(d[POS_CODE+2:POS_CODE]);
        return c;
    endfunction

endpackage

// File: rtl/wlock_decode.sv
module wlock_decode
    import wlock_pkg::*;
#(
    parameter int ADDR_W = 15,
    parameter int PAGE_W = 6
) (
    input  lock_code_t        code,
    input  logic [ADDR_W-1:0] addr,
    output logic              locked
);
    localparam int N_PG = 4;

    logic [N_PG-1:0] low_hit;

    // Region of 2**g pages starting at address zero.
    for (genvar g = 0; g < N_PG; g++) begin : g_pages
        assign low_hit[g] = (addr[ADDR_W-1:PAGE_W+g] == '0);
    end

    always_comb begin
        unique case (code)
            LK_NONE:  locked = 1'b0;
            LK_TOP_Q: locked = &addr[ADDR_W-1:ADDR_W-2];
            LK_TOP_H: locked = addr[ADDR_W-1];
            LK_ALL:   locked = 1'b1;
            default:  locked = low_hit[code[1:0]];
        endcase
    end
endmodule

// File: rtl/wlock_regs.sv
module wlock_regs
    import wlock_pkg::*;
#(
    parameter logic       INIT_PEN  = 1'b0,
    parameter logic [2:0] INIT_CODE = 3'b000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wp_pin,
    input  logic              sw_active,
    input  logic              commit_ok,
    input  logic [STAT_W-1:0] sw_data,
    output prot_cfg_t         cfg,
    output logic              cancel_q
);
    logic wp_prev;
    logic wp_fell;

    assign wp_fell = wp_prev && !wp_pin;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg.pen  <= INIT_PEN;
            cfg.code <= lock_code_t'(INIT_CODE);
            wp_prev  <= 1'b1;
            cancel_q <= 1'b0;
        end else begin
            wp_prev <= wp_pin;
            if (commit_ok)
                cfg <= unpack_cfg(sw_data);
            if (!sw_active)
                cancel_q <= 1'b0;
            else if (wp_fell && cfg.pen)
                cancel_q <= 1'b1;
        end
    end
endmodule

// File: rtl/wlock_unit.sv
module wlock_unit
    import wlock_pkg::*;
#(
    parameter int         ADDR_W    = 15,
    parameter int         PAGE_W    = 6,
    parameter logic       INIT_PEN  = 1'b0,
    parameter logic [2:0] INIT_CODE = 3'b000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wp_pin,
    input  logic              sw_active,
    input  logic              sw_commit,
    input  logic [7:0]        sw_data,
    input  logic              wel,
    input  logic              busy,
    input  logic [ADDR_W-1:0] arr_addr,
    output logic [7:0]        status,
    output logic              arr_permit,
    output logic              stat_permit
);
    prot_cfg_t cfg;
    logic      cancel_q;
    logic      hw_prot;
    logic      locked;
    logic      ready;

    assign ready       = wel && !busy;
    assign hw_prot     = !wp_pin && cfg.pen;
    assign stat_permit = ready && !hw_prot && !cancel_q;

    wlock_regs #(
        .INIT_PEN  (INIT_PEN),
        .INIT_CODE (INIT_CODE)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wp_pin    (wp_pin),
        .sw_active (sw_active),
        .commit_ok (sw_commit && stat_permit),
        .sw_data   (sw_data),
        .cfg       (cfg),
        .cancel_q  (cancel_q)
    );

    wlock_decode #(
        .ADDR_W (ADDR_W),
        .PAGE_W (PAGE_W)
    ) u_dec (
        .code   (cfg.code),
        .addr   (arr_addr),
        .locked (locked)
    );

    assign arr_permit = ready && !locked;
    assign status     = pack_status(cfg, wel, busy);
endmodule

// File: rtl/wlock_chk.sv
module wlock_chk (
    input logic       clk,
    input logic       rst,
    input logic       wp_pin,
    input logic       sw_commit,
    input logic [7:0] sw_data,
    input logic       wel,
    input logic       busy,
    input logic [7:0] status,
    input logic       arr_permit,
    input logic       stat_permit
);
    p_unused_zero_r1: assert property (@(posedge clk) disable iff (rst)
        status[6:5] == 2'b00);

    p_commit_apply_r2: assert property (@(posedge clk) disable iff (rst)
        sw_commit && stat_permit |=>
            status[7] == $past(sw_data[7]) && status[4:2] == $past(sw_data[4:2]));

    p_refused_hold_r3: assert property (@(posedge clk) disable iff (rst)
        sw_commit && !stat_permit |=> $stable(status[7]) && $stable(status[4:2]));

    p_hw_block_r4: assert property (@(posedge clk) disable iff (rst)
        !wp_pin && status[7] |-> !stat_permit);

    p_full_lock_r6: assert property (@(posedge clk) disable iff (rst)
        status[4:2] == 3'b011 |-> !arr_permit);

    p_arr_gate_r10: assert property (@(posedge clk) disable iff (rst)
        arr_permit |-> wel && !busy);
endmodule

bind wlock_unit wlock_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .wp_pin      (wp_pin),
    .sw_commit   (sw_commit),
    .sw_data     (sw_data),
    .wel         (wel),
    .busy        (busy),
    .status      (status),
    .arr_permit  (arr_permit),
    .stat_permit (stat_permit)
);

// File: tb/sim_wlock_unit.sv
module sim_wlock_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wp_pin = 1'b1;
    logic        sw_active = 1'b0;
    logic        sw_commit = 1'b0;
    logic [7:0]  sw_data = 8'h00;
    logic        wel = 1'b0;
    logic        busy = 1'b0;
    logic [14:0] arr_addr = '0;
    logic [7:0]  status;
    logic        arr_permit;
    logic        stat_permit;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    wlock_unit u0 (
        .clk(clk), .rst(rst), .wp_pin(wp_pin), .sw_active(sw_active),
        .sw_commit(sw_commit), .sw_data(sw_data), .wel(wel), .busy(busy),
        .arr_addr(arr_addr), .status(status), .arr_permit(arr_permit),
        .stat_permit(stat_permit)
    );

    // {lock code, address, expected permit}
    localparam int NV = 18;
    localparam logic [18:0] VEC [NV] = '{
        {3'b000, 15'h7FFF, 1'b1}, {3'b000, 15'h0000, 1'b1},
        {3'b001, 15'h5FFF, 1'b1}, {3'b001, 15'h6000, 1'b0},
        {3'b010, 15'h3FFF, 1'b1}, {3'b010, 15'h4000, 1'b0},
        {3'b011, 15'h0000, 1'b0}, {3'b011, 15'h7FFF, 1'b0},
        {3'b100, 15'h003F, 1'b0}, {3'b100, 15'h0040, 1'b1},
        {3'b101, 15'h007F, 1'b0}, {3'b101, 15'h0080, 1'b1},
        {3'b110, 15'h00FF, 1'b0}, {3'b110, 15'h0100, 1'b1},
        {3'b111, 15'h01FF, 1'b0}, {3'b111, 15'h0200, 1'b1},
        {3'b111, 15'h7FFF, 1'b1}, {3'b001, 15'h7FFF, 1'b0}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Raise transfer flag, commit one cycle later, then finish the transfer.
    task automatic commit(input logic [7:0] d);
        @(negedge clk); sw_active = 1'b1; sw_data = d;
        @(negedge clk); sw_commit = 1'b1;
        @(negedge clk); sw_commit = 1'b0; sw_active = 1'b0;
        #1;
    endtask

    initial begin
        #(5.0 * 150000);
        bad++; total++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1 reset status", status, 8'h00);
        check("R3 permit needs wel", {7'b0, stat_permit}, 8'h00);

        // R3: refused without wel, and while busy
        commit(8'h9C);
        check("R3 no wel", status, 8'h00);
        @(negedge clk); wel = 1'b1; busy = 1'b1;
        commit(8'h9C);
        check("R3 busy", status, 8'h03);
        @(negedge clk); busy = 1'b0;

        // R2: ignored bits and mirrored bits
        commit(8'h63);
        check("R2 ignored bits", status, 8'h02);
        commit(8'h14);
        check("R2 code update", status, 8'h16);
        @(negedge clk); busy = 1'b1; #1;
        check("R1 busy mirror", status, 8'h17);
        @(negedge clk); busy = 1'b0;

        // R6/R7: lock region table
        for (int i = 0; i < NV; i++) begin
            commit({3'b000, VEC[i][18:16], 2'b00});
            @(negedge clk); arr_addr = VEC[i][15:1]; #1;
            check((VEC[i][18] ? "R7 page lock" : "R6 top lock"),
                  {7'b0, arr_permit}, {7'b0, VEC[i][0]});
        end

        // R10: permit gated by wel and busy
        commit(8'h00);
        @(negedge clk); arr_addr = 15'h1234; wel = 1'b0; #1;
        check("R10 no wel", {7'b0, arr_permit}, 8'h00);
        @(negedge clk); wel = 1'b1; busy = 1'b1; #1;
        check("R10 busy", {7'b0, arr_permit}, 8'h00);
        @(negedge clk); busy = 1'b0;

        // R5: pin low with enable clear does not block
        @(negedge clk); wp_pin = 1'b0;
        commit(8'h08);
        check("R5 pin low pen0", status, 8'h0A);
        @(negedge clk); wp_pin = 1'b1;
        commit(8'h88);
        check("R5 pin high", status, 8'h8A);

        // R4: hardware protection refuses status writes
        @(negedge clk); wp_pin = 1'b0; #1;
        check("R4 permit low", {7'b0, stat_permit}, 8'h00);
        commit(8'h00);
        check("R4 refused", status, 8'h8A);

        // R8: locked refused, unlocked allowed under hw protection
        @(negedge clk); arr_addr = 15'h1000; #1;
        check("R8 unlocked ok", {7'b0, arr_permit}, 8'h01);
        @(negedge clk); arr_addr = 15'h5000; #1;
        check("R8 locked", {7'b0, arr_permit}, 8'h00);
        @(negedge clk); wp_pin = 1'b1; #1;
        check("R8 locked pin high", {7'b0, arr_permit}, 8'h00);

        // R9: pin fall during transfer with enable set cancels
        @(negedge clk); sw_active = 1'b1; sw_data = 8'h00;
        @(negedge clk); wp_pin = 1'b0;
        @(negedge clk); wp_pin = 1'b1;
        @(negedge clk); sw_commit = 1'b1;
        @(negedge clk); sw_commit = 1'b0; sw_active = 1'b0; #1;
        check("R9 cancelled", status, 8'h8A);
        commit(8'h00);
        check("R9 next transfer ok", status, 8'h02);

        // R9: pin fall with enable clear does not cancel
        @(negedge clk); sw_active = 1'b1; sw_data = 8'h10;
        @(negedge clk); wp_pin = 1'b0;
        @(negedge clk); wp_pin = 1'b1;
        @(negedge clk); sw_commit = 1'b1;
        @(negedge clk); sw_commit = 1'b0; sw_active = 1'b0; #1;
        check("R9 pen0 no cancel", status, 8'h12);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule